// File: doc/BRIEF.md
# Option-Select Port Arbiter for a Card-Slot I/O Bus

This block sits on an 8-bit I/O bus with 16-bit addresses. It holds three control bytes: the system setup-control byte, the adapter-setup byte and system control port A. It also decides where each access to the eight-address option-select window goes. The window is 0x100 to 0x107.

A window access can go to one of four places:
- the motherboard (planar) register file;
- a small built-in video identity and option responder;
- the card slot named by the adapter-setup byte;
- nowhere.

The planar register file and the card slots sit outside the block. Each is reached through a plain request/response side port. Its read data comes back combinationally in the same cycle.

From port A the block also derives a one-cycle CPU soft-reset pulse and an alternate A20 gate level. It drives a slot-select index and an adapter-setup enable level to the card side.

The host bus has no back-pressure, so no ready signal exists. Every cycle with `io_req` high is one complete access. A write commits at the clock edge that ends that cycle. Read data is valid combinationally while `io_req` is high. The side ports inherit this rule: a side request lasts exactly the one bus cycle, and the side must answer within it. Routing always uses the control bytes as they stood before the current cycle's write. A write to the setup-control byte therefore changes the route from the next access on.

Top module: `mcsetup_arbiter`

## Requirements
- R1: After reset the setup-control byte is 0xFF, the adapter-setup byte is 0x00 and port A is 0x00. Consequently `soft_rst`, `a20_alt`, `slot_sel` and `adp_en` are all 0, and reads of 0x94, 0x96 and 0x92 return 0xFF, 0x70 and 0x00.
- R2: While setup-control bit 7 is 0, every window access raises `pl_req` for that cycle. It also drives `pl_idx` = address bits 2:0 and passes `io_wr` and `io_wdata` through. Read data is `pl_rdata`. No slot request is raised.
- R3: While setup-control bit 7 is 1 and bit 5 is 0, the video responder answers with no side request. Reads of 0x100 return 0xFD, reads of 0x101 return 0xEF, and reads of 0x103 to 0x107 return 0xFF.
- R4: In the video route, address 0x102 reads and writes a local video option byte, which resets to 0x00. The byte keeps its value while other routes are active.
- R5: While setup-control bits 7 and 5 are both 1 and adapter-setup bit 3 is 1, a window access raises `sl_req`. It drives `sl_idx` = address bits 2:0 and passes `io_wr` and `io_wdata` through. Read data is `sl_rdata`.
- R6: While setup-control bits 7 and 5 are both 1 and adapter-setup bit 3 is 0, window reads return 0xFF and window writes raise no side request.
- R7: A write to 0x96 stores the byte. `slot_sel` (bits 2:0) and `adp_en` (bit 3) follow it from the cycle after the write. A read of 0x96 returns the stored byte ORed with 0x70.
- R8: A write to 0x92 with data bit 0 = 1, while stored port A bit 0 is 0, makes `soft_rst` high for exactly the one cycle after the write. A write with bit 0 already stored as 1 gives no pulse.
- R9: `a20_alt` equals bit 1 of the stored port A byte and changes in the cycle after the write. Reads of 0x92 and 0x94 return the stored bytes.
- R10: Reads of any address outside 0x92, 0x94, 0x96 and the window return 0xFF. This includes 0x91, 0x93, 0xFF, 0x108 and 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Bus access this cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| pl_req | output | 1 | Planar side request |
| pl_wr | output | 1 | Planar side write flag |
| pl_idx | output | 3 | Planar register index in window |
| pl_wdata | output | 8 | Planar write data |
| pl_rdata | input | 8 | Planar read data, same cycle |
| sl_req | output | 1 | Slot side request |
| sl_wr | output | 1 | Slot side write flag |
| sl_idx | output | 3 | Slot register index in window |
| sl_wdata | output | 8 | Slot write data |
| sl_rdata | input | 8 | Slot read data, same cycle |
| slot_sel | output | 3 | Selected slot index, registered |
| adp_en | output | 1 | Adapter setup enable, registered |
| soft_rst | output | 1 | One-cycle CPU soft-reset pulse |
| a20_alt | output | 1 | Alternate A20 gate |

## Verification
One write to port A does two things in the same cycle: it raises the soft-reset pulse and moves the A20 gate. The bench writes 0x03 over a cleared port A and checks both outputs in the following cycle. It then rewrites with bit 0 already set, where the gate must move while the pulse stays low.

A second coincidence is a setup-control write followed at once by a window access. The bench changes the route and judges, from the read data and the side-request counts, that the very next access already took the new route. It also checks that the video option byte survived a period spent in the planar route.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_PLANAR = 2'd1,
    RT_VIDEO  = 2'd2,
    RT_SLOT   = 2'd3
  } route_t;

  localparam int unsigned SETUP_IO_BIT  = 7;
  localparam int unsigned SETUP_VID_BIT = 5;
  localparam int unsigned ADP_EN_BIT    = 3;
endpackage

// File: rtl/mcs_regs.sv
module mcs_regs #(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_porta,
  input  logic          wr_setup,
  input  logic          wr_adp,
  input  logic          wr_vid,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] setup_q,
  output logic [DW-1:0] adp_q,
  output logic [DW-1:0] porta_q,
  output logic [DW-1:0] vid_q,
  output logic          soft_rst
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_q  <= '1;
      adp_q    <= '0;
      porta_q  <= '0;
      vid_q    <= '0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= wr_porta && wdata[0] && !porta_q[0];
      if (wr_porta) porta_q <= wdata;
      if (wr_setup) setup_q <= wdata;
      if (wr_adp)   adp_q   <= wdata;
      if (wr_vid)   vid_q   <= wdata;
    end
  end

  // R8
  soft_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  // R7
  adp_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_adp |=> adp_q == $past(wdata));

  // R8
  porta_bit0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> porta_q[0]);
endmodule

// File: rtl/mcs_route.sv
module mcs_route #(
  parameter int unsigned DW = 8
) (
  input  logic            in_window,
  input  logic [DW-1:0]   setup_q,
  input  logic [DW-1:0]   adp_q,
  output mcs_pkg::route_t route
);
  import mcs_pkg::*;

  always_comb begin
    if (!in_window)                   route = RT_NONE;
    else if (!setup_q[SETUP_IO_BIT])  route = RT_PLANAR;
    else if (!setup_q[SETUP_VID_BIT]) route = RT_VIDEO;
    else if (adp_q[ADP_EN_BIT])       route = RT_SLOT;
    else                              route = RT_NONE;
  end
endmodule

// File: rtl/mcs_video.sv
module mcs_video #(
  parameter int unsigned DW    = 8,
  parameter int unsigned IW    = 3,
  parameter logic [DW-1:0] ID0 = 8'hFD,
  parameter logic [DW-1:0] ID1 = 8'hEF
) (
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] vid_q,
  output logic [DW-1:0] rdata
);
  localparam int unsigned NENT = 1 << IW;
  logic [DW-1:0] table_w [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    if (g == 0)      begin : g_id0 assign table_w[g] = ID0;   end
    else if (g == 1) begin : g_id1 assign table_w[g] = ID1;   end
    else if (g == 2) begin : g_opt assign table_w[g] = vid_q; end
    else             begin : g_ff  assign table_w[g] = '1;    end
  end

  assign rdata = table_w[idx];
endmodule

// File: rtl/mcsetup_arbiter.sv
module mcsetup_arbiter #(
  parameter int unsigned AW             = 16,
  parameter int unsigned DW             = 8,
  parameter int unsigned SW             = 3,
  parameter logic [15:0] ADDR_PORTA     = 16'h0092,
  parameter logic [15:0] ADDR_SETUP     = 16'h0094,
  parameter logic [15:0] ADDR_ADP       = 16'h0096,
  parameter logic [15:0] ADDR_WIN       = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_req,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          pl_req,
  output logic          pl_wr,
  output logic [2:0]    pl_idx,
  output logic [DW-1:0] pl_wdata,
  input  logic [DW-1:0] pl_rdata,
  output logic          sl_req,
  output logic          sl_wr,
  output logic [2:0]    sl_idx,
  output logic [DW-1:0] sl_wdata,
  input  logic [DW-1:0] sl_rdata,
  output logic [SW-1:0] slot_sel,
  output logic          adp_en,
  output logic          soft_rst,
  output logic          a20_alt
);
  import mcs_pkg::*;

  localparam int unsigned IW = 3;
  localparam logic [DW-1:0] ADP_RD_OR = 8'h70;

  logic          in_window;
  logic          wr_cyc;
  logic [DW-1:0] setup_q, adp_q, porta_q, vid_q, vid_rd;
  route_t        route;

  assign in_window = (io_addr[AW-1:IW] == ADDR_WIN[AW-1:IW]);
  assign wr_cyc    = io_req && io_wr;

  mcs_regs #(.DW(DW), .SW(SW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_porta (wr_cyc && io_addr == ADDR_PORTA),
    .wr_setup (wr_cyc && io_addr == ADDR_SETUP),
    .wr_adp   (wr_cyc && io_addr == ADDR_ADP),
    .wr_vid   (wr_cyc && route == RT_VIDEO && io_addr[IW-1:0] == 3'd2),
    .wdata    (io_wdata),
    .setup_q  (setup_q),
    .adp_q    (adp_q),
    .porta_q  (porta_q),
    .vid_q    (vid_q),
    .soft_rst (soft_rst)
  );

  mcs_route #(.DW(DW)) u_route (
    .in_window (in_window),
    .setup_q   (setup_q),
    .adp_q     (adp_q),
    .route     (route)
  );

  mcs_video #(.DW(DW), .IW(IW)) u_video (
    .idx   (io_addr[IW-1:0]),
    .vid_q (vid_q),
    .rdata (vid_rd)
  );

  assign pl_req   = io_req && route == RT_PLANAR;
  assign pl_wr    = io_wr;
  assign pl_idx   = io_addr[IW-1:0];
  assign pl_wdata = io_wdata;
  assign sl_req   = io_req && route == RT_SLOT;
  assign sl_wr    = io_wr;
  assign sl_idx   = io_addr[IW-1:0];
  assign sl_wdata = io_wdata;
  assign slot_sel = adp_q[SW-1:0];
  assign adp_en   = adp_q[ADP_EN_BIT];
  assign a20_alt  = porta_q[1];

  always_comb begin
    io_rdata = '1;
    if (io_addr == ADDR_PORTA)      io_rdata = porta_q;
    else if (io_addr == ADDR_SETUP) io_rdata = setup_q;
    else if (io_addr == ADDR_ADP)   io_rdata = adp_q | ADP_RD_OR;
    else if (in_window) begin
      case (route)
        RT_PLANAR: io_rdata = pl_rdata;
        RT_VIDEO:  io_rdata = vid_rd;
        RT_SLOT:   io_rdata = sl_rdata;
        default:   io_rdata = '1;
      endcase
    end
  end

  // R2
  side_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pl_req, sl_req}));

  // R3
  video_no_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && in_window && setup_q[7] && !setup_q[5]) |-> (!pl_req && !sl_req));

  // R9
  a20_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && io_addr == ADDR_PORTA) |=> a20_alt == $past(io_wdata[1]));

  // R7
  slot_sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && io_addr == ADDR_ADP) |=> slot_sel == $past(io_wdata[SW-1:0]));
endmodule

// File: tb/mcsetup_arbiter_test.sv
module mcsetup_arbiter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_req = 0, io_wr = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic        pl_req, pl_wr, sl_req, sl_wr, adp_en, soft_rst, a20_alt;
  logic [2:0]  pl_idx, sl_idx, slot_sel;
  logic [7:0]  pl_wdata, sl_wdata, pl_rdata, sl_rdata;

  int errors = 0, checks = 0;
  int pl_cnt = 0, sl_cnt = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  assign pl_rdata = 8'hA0 | {5'b0, pl_idx};
  assign sl_rdata = {2'b01, slot_sel, sl_idx};

  mcsetup_arbiter uut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pl_req(pl_req), .pl_wr(pl_wr), .pl_idx(pl_idx), .pl_wdata(pl_wdata), .pl_rdata(pl_rdata),
    .sl_req(sl_req), .sl_wr(sl_wr), .sl_idx(sl_idx), .sl_wdata(sl_wdata), .sl_rdata(sl_rdata),
    .slot_sel(slot_sel), .adp_en(adp_en), .soft_rst(soft_rst), .a20_alt(a20_alt));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: compares reads against the scoreboard, counts side requests
  always @(negedge clk) begin
    if (rst_n && io_req) begin
      if (pl_req) pl_cnt++;
      if (sl_req) sl_cnt++;
      if (!io_wr && exp_q.size() > 0) chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [15:0] a, logic [7:0] exp, string req);
    @(posedge clk); #1;
    io_req = 1; io_wr = 0; io_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(posedge clk); #1;
    io_req = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    io_req = 1; io_wr = 1; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    io_req = 0; io_wr = 0;
  endtask

  // write with a side-port observation at mid-cycle
  task automatic wr_side(logic [15:0] a, logic [7:0] d, bit slot, string req);
    @(posedge clk); #1;
    io_req = 1; io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    if (slot) begin
      chk(req, {7'b0, sl_req}, 8'h01);
      chk(req, {7'b0, sl_wr}, 8'h01);
      chk(req, sl_wdata, d);
      chk(req, {5'b0, sl_idx}, {5'b0, a[2:0]});
    end else begin
      chk(req, {7'b0, pl_req}, 8'h01);
      chk(req, {7'b0, pl_wr}, 8'h01);
      chk(req, pl_wdata, d);
      chk(req, {5'b0, pl_idx}, {5'b0, a[2:0]});
    end
    @(posedge clk); #1;
    io_req = 0; io_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p0, s0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 soft_rst", {7'b0, soft_rst}, 8'h00);
    chk("R1 a20", {7'b0, a20_alt}, 8'h00);
    chk("R1 slot_sel", {5'b0, slot_sel}, 8'h00);
    chk("R1 adp_en", {7'b0, adp_en}, 8'h00);
    rd(16'h0094, 8'hFF, "R1 setup");
    rd(16'h0096, 8'h70, "R1 adp");
    rd(16'h0092, 8'h00, "R1 porta");

    // R6: route to nowhere
    p0 = pl_cnt; s0 = sl_cnt;
    rd(16'h0100, 8'hFF, "R6 rd100");
    rd(16'h0103, 8'hFF, "R6 rd103");
    wr(16'h0104, 8'h44);
    chk("R6 no side req", 8'(pl_cnt - p0 + sl_cnt - s0), 8'h00);

    // R7 adapter setup byte
    wr(16'h0096, 8'h0D);
    chk("R7 slot_sel", {5'b0, slot_sel}, 8'h05);
    chk("R7 adp_en", {7'b0, adp_en}, 8'h01);
    rd(16'h0096, 8'h7D, "R7 rd96");
    wr(16'h0096, 8'h8A);
    chk("R7 slot_sel2", {5'b0, slot_sel}, 8'h02);
    rd(16'h0096, 8'hFA, "R7 rd96b");

    // R5 slot forwarding
    s0 = sl_cnt;
    rd(16'h0105, 8'h55, "R5 rd105");
    chk("R5 sl count", 8'(sl_cnt - s0), 8'h01);
    wr_side(16'h0107, 8'h3C, 1, "R5 wr107");

    // R3 video identity, route changes on the very next access
    wr(16'h0094, 8'hDF);
    p0 = pl_cnt; s0 = sl_cnt;
    rd(16'h0100, 8'hFD, "R3 rd100");
    rd(16'h0101, 8'hEF, "R3 rd101");
    rd(16'h0103, 8'hFF, "R3 rd103");
    rd(16'h0107, 8'hFF, "R3 rd107");
    // R4 video option byte
    rd(16'h0102, 8'h00, "R4 reset val");
    wr(16'h0102, 8'h5A);
    rd(16'h0102, 8'h5A, "R4 rd102");
    chk("R3 no side req", 8'(pl_cnt - p0 + sl_cnt - s0), 8'h00);

    // R2 planar route
    wr(16'h0094, 8'h7F);
    rd(16'h0106, 8'hA6, "R2 rd106");
    rd(16'h0102, 8'hA2, "R2 rd102");
    wr_side(16'h0101, 8'h99, 0, "R2 wr101");
    rd(16'h0094, 8'h7F, "R9 rd94");

    // R4 video byte retained
    wr(16'h0094, 8'hDF);
    rd(16'h0102, 8'h5A, "R4 retained");

    // R8 / R9 port A
    wr(16'h0092, 8'h03);
    chk("R8 pulse", {7'b0, soft_rst}, 8'h01);
    chk("R9 a20 set", {7'b0, a20_alt}, 8'h01);
    @(posedge clk); #1;
    chk("R8 pulse one cycle", {7'b0, soft_rst}, 8'h00);
    rd(16'h0092, 8'h03, "R9 rd92");
    wr(16'h0092, 8'h01);
    chk("R8 no pulse 1to1", {7'b0, soft_rst}, 8'h00);
    chk("R9 a20 clr", {7'b0, a20_alt}, 8'h00);
    wr(16'h0092, 8'h00);
    chk("R8 no pulse clear", {7'b0, soft_rst}, 8'h00);
    wr(16'h0092, 8'h01);
    chk("R8 pulse again", {7'b0, soft_rst}, 8'h01);

    // R10 unmapped
    rd(16'h0091, 8'hFF, "R10 rd91");
    rd(16'h0093, 8'hFF, "R10 rd93");
    rd(16'h00FF, 8'hFF, "R10 rdFF");
    rd(16'h0108, 8'hFF, "R10 rd108");
    rd(16'h0200, 8'hFF, "R10 rd200");

    @(posedge clk); #1;
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule